// File: doc/BRIEF.md
# PLL Parameter Search Engine

This block finds a clock-synthesizer setting on its own. Software or a boot sequencer gives it three unsigned 32-bit numbers in hertz: the reference input frequency, the wanted output frequency and the largest acceptable error. It then pulses `start`. The engine tries every pairing of a 4-bit post-divider code with a reference divider. For each pairing it works out the phase-detector frequency, the feedback multiplier, the VCO frequency and the output frequency, all with rounded integer arithmetic. It keeps the best pairing that passes every legality bound.

When the sweep is over, the engine raises `done` for one cycle. At the same moment it presents three results:
- a flag that says whether any pairing qualified;
- the winning setting packed into a 25-bit clock-mode word;
- the output frequency that setting actually produces.

These results stay unchanged until the next search completes. All divisions run on one shared iterative divider. All products run on one shared iterative multiplier. A pairing is dropped as soon as its phase-detector frequency or its multiplier is out of range, so the cost of a sweep depends on the reference frequency.

Top module: `pll_cfg_search`

## Requirements
- R1: A one-cycle `start` seen while the engine is idle begins a search on the values of `xin_hz`, `target_hz` and `tol_hz` present at that clock edge. `done` is high for exactly one cycle once all 1024 pairings have been evaluated. A `start` during a running search has no effect on its result.
- R2: The sweep order is fixed. The post code runs 0 to 15 in the outer loop, with post value 1 for code 0 and twice the code otherwise. The reference divider `d` runs from 64 down to 1 in the inner loop.
- R3: Every quotient is rounded to nearest as ((2·n / d) + 1) >> 1 in integer arithmetic, giving:
  - phase-detector frequency P = rnd(xin / d);
  - multiplier M = rnd(target·post·d / xin);
  - VCO frequency V = rnd(xin·M / d);
  - output frequency F = rnd(V / post).
- R4: A pairing is legal only when all of these hold:
  - P ≥ 250000;
  - 1 ≤ M ≤ 1024;
  - V ≥ 99000000;
  - V ≤ 201000000, or V ≤ target + tol;
  - |F − target| ≤ the best error so far.
- R5: The best error starts at `tol_hz`. Each legal pairing replaces the stored one and lowers the best error to its own error. A legal pairing whose error equals the stored one also replaces it, so the later pairing wins a tie.
- R6: When no pairing is legal, `found` is 0 and both `mode_word` and `achieved_hz` are 0 after `done`.
- R7: When `found` is 1, `mode_word` has these fields:
  - bit 24 = 1;
  - bits 23:18 = d−1;
  - bits 17:8 = M−1;
  - bits 7:4 = (code−1) mod 16, so post-by-1 reads 1111;
  - bits 3:2 = 00;
  - bits 1:0 = 11.
- R8: When `found` is 1, `achieved_hz` equals F of the winning pairing.
- R9: `found`, `mode_word` and `achieved_hz` change only in the cycle where `done` is high. Between searches, changes on the frequency inputs have no effect on them.
- R10: With `xin_hz` = 0, no pairing is legal, because P rounds to 0. A pairing whose M rounds to 0 is also illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (ignored while busy) |
| xin_hz | input | 32 | Reference input frequency in Hz |
| target_hz | input | 32 | Wanted output frequency in Hz |
| tol_hz | input | 32 | Largest acceptable error in Hz |
| done | output | 1 | One-cycle pulse at the end of a search |
| found | output | 1 | A legal setting was found |
| mode_word | output | 25 | Packed clock-mode word of the winner |
| achieved_hz | output | 32 | Output frequency of the winner in Hz |

## Verification
The assertions assume the following about the inputs:
- reset is held for at least two clock edges;
- target plus tolerance fits in 32 bits, so a winner's frequency is never truncated;
- a `start` pulse lasts a single cycle.

The bench keeps reference frequencies between 4 MHz and 20 MHz, targets below about 334 MHz and tolerances below 200 kHz. This keeps every intermediate value far from the 48-bit datapath limit and keeps each sweep short.

Directed cases cover:
- an exact hit that needs the VCO-ceiling exception;
- a fractional ratio;
- a target that cannot be reached;
- a zero reference frequency.

Seeded random triples fill in the rest.

// File: rtl/pllsrch_pkg.sv
// Package: shared constants, FSM state type and the mode-word packer for the
// PLL parameter search engine. Assumes field widths fixed by the mode layout.
package pllsrch_pkg;

    localparam int unsigned DIVD_W   = 7;           // holds 1..64
    localparam int unsigned DIVD_TOP = 64;
    localparam int unsigned CODE_W   = 4;
    localparam int unsigned POST_W   = 5;           // holds 1..30
    localparam int unsigned MULB_W   = 11;          // post*divd <= 1920, mult <= 1024
    localparam int unsigned MODE_W   = 25;
    localparam int unsigned PFD_MIN  = 250000;
    localparam int unsigned MULT_MAX = 1024;
    localparam int unsigned VCO_MIN  = 99000000;
    localparam int unsigned VCO_MAX  = 201000000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PFD,
        ST_MULN,
        ST_MDIV,
        ST_MULV,
        ST_VDIV,
        ST_ODIV,
        ST_JUDGE,
        ST_ADV,
        ST_FIN
    } st_e;

    // Pack a winning candidate into the clock-mode word layout.
    function automatic logic [MODE_W-1:0] pack_mode(
        input logic [CODE_W-1:0] code,
        input logic [DIVD_W-1:0] divd,
        input logic [MULB_W-1:0] mult
    );
        return {1'b1,
                6'(divd - 7'd1),
                10'(mult - 11'd1),
                4'(code - 4'd1),
                2'b00,
                2'b11};
    endfunction

endpackage

// File: rtl/pllsrch_div.sv
// Iterative restoring divider: quotient = floor(num / den), STEP bits per cycle.
// Assumes den is nonzero whenever the quotient matters (den = 0 yields all ones).
// The start pulse is accepted only while idle; done is a one-cycle pulse and
// quo/rem hold until the next start.
module pllsrch_div #(
    parameter int unsigned NW   = 48,
    parameter int unsigned DW   = 32,
    parameter int unsigned STEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          busy,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int unsigned ITER = (NW + STEP - 1) / STEP;
    localparam int unsigned PW   = ITER * STEP;
    localparam int unsigned CW   = $clog2(ITER + 1);

    logic [PW-1:0] work, work_nx;
    logic [DW:0]   rem, rem_nx;
    logic [DW-1:0] den_q;
    logic [NW-1:0] num_q;
    logic [CW-1:0] cnt;

    // One iteration: STEP restoring shift-subtract stages.
    always_comb begin
        rem_nx  = rem;
        work_nx = work;
        for (int i = 0; i < int'(STEP); i++) begin
            rem_nx  = {rem_nx[DW-1:0], work_nx[PW-1]};
            work_nx = {work_nx[PW-2:0], 1'b0};
            if (rem_nx >= {1'b0, den_q}) begin
                rem_nx     = rem_nx - {1'b0, den_q};
                work_nx[0] = 1'b1;
            end
        end
    end

    // Sequencer: load on start, iterate ITER times, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work  <= '0;
            rem   <= '0;
            den_q <= '0;
            num_q <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                work  <= PW'(num);
                rem   <= '0;
                den_q <= den;
                num_q <= num;
                cnt   <= CW'(ITER);
                busy  <= 1'b1;
            end else if (busy) begin
                work <= work_nx;
                rem  <= rem_nx;
                cnt  <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = work[NW-1:0];

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_q != '0) |->
        (((NW+DW)'(quo) * (NW+DW)'(den_q) + (NW+DW)'(rem) == (NW+DW)'(num_q))
         && (rem < {1'b0, den_q}))); // R3

endmodule

// File: rtl/pllsrch_mul.sv
// Iterative shift-add multiplier: prod = a * b, STEP multiplier bits per cycle.
// The start pulse is accepted only while idle; done is a one-cycle pulse and
// prod holds until the next start.
module pllsrch_mul #(
    parameter int unsigned AW   = 32,
    parameter int unsigned BW   = 11,
    parameter int unsigned STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    a,
    input  logic [BW-1:0]    b,
    output logic             busy,
    output logic             done,
    output logic [AW+BW-1:0] prod
);
    localparam int unsigned ITER = (BW + STEP - 1) / STEP;
    localparam int unsigned PBW  = ITER * STEP;
    localparam int unsigned XW   = AW + PBW;
    localparam int unsigned CW   = $clog2(ITER + 1);

    logic [XW-1:0]  acc, acc_nx, a_sh;
    logic [PBW-1:0] b_sh;
    logic [AW-1:0]  a_q;
    logic [BW-1:0]  b_q;
    logic [CW-1:0]  cnt;

    // One iteration: add the shifted multiplicand for each set multiplier bit.
    always_comb begin
        acc_nx = acc;
        for (int i = 0; i < int'(STEP); i++) begin
            if (b_sh[i]) acc_nx = acc_nx + (a_sh << i);
        end
    end

    // Sequencer: load on start, iterate ITER times, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            a_sh <= '0;
            b_sh <= '0;
            a_q  <= '0;
            b_q  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                acc  <= '0;
                a_sh <= XW'(a);
                b_sh <= PBW'(b);
                a_q  <= a;
                b_q  <= b;
                cnt  <= CW'(ITER);
                busy <= 1'b1;
            end else if (busy) begin
                acc  <= acc_nx;
                a_sh <= a_sh << STEP;
                b_sh <= b_sh >> STEP;
                cnt  <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign prod = acc[AW+BW-1:0];

    AST_MUL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod == (AW+BW)'(a_q) * (AW+BW)'(b_q))); // R3

endmodule

// File: rtl/pllsrch_judge.sv
// Combinational legality judge for one candidate. Gives the early-prune
// verdicts (phase-detector frequency, multiplier range) and the full
// acceptance against the running best error. Pure logic, no state.
module pllsrch_judge #(
    parameter int unsigned FW = 32,
    parameter int unsigned QW = 48
) (
    input  logic [FW-1:0] xin,
    input  logic [FW-1:0] tgt,
    input  logic [FW-1:0] tol,
    input  logic [FW-1:0] best_err,
    input  logic [QW-1:0] fpfd,
    input  logic [QW-1:0] mult,
    input  logic [QW-1:0] fvco,
    input  logic [QW-1:0] fout,
    output logic          pfd_ok,
    output logic          mult_ok,
    output logic          accept,
    output logic [QW-1:0] err
);
    import pllsrch_pkg::*;

    logic vco_lo_ok, vco_hi_ok;

    // Range bounds on each candidate quantity.
    always_comb begin
        pfd_ok    = (xin != '0) && (fpfd >= QW'(PFD_MIN));
        mult_ok   = (mult != '0) && (mult <= QW'(MULT_MAX));
        vco_lo_ok = fvco >= QW'(VCO_MIN);
        vco_hi_ok = (fvco <= QW'(VCO_MAX)) || (fvco <= (QW'(tgt) + QW'(tol)));
    end

    // Absolute error and final verdict.
    always_comb begin
        err    = (fout >= QW'(tgt)) ? (fout - QW'(tgt)) : (QW'(tgt) - fout);
        accept = pfd_ok && mult_ok && vco_lo_ok && vco_hi_ok && (err <= QW'(best_err));
    end

endmodule

// File: rtl/pll_cfg_search.sv
// PLL parameter search engine, top level. Sweeps 16 post codes (outer) by 64
// reference dividers (inner, descending), evaluates each candidate on the
// shared divider and multiplier, prunes early on range failures, and tracks the
// best legal one. Inputs are latched at start; results appear with done.
module pll_cfg_search #(
    parameter int unsigned FREQ_W   = 32,
    parameter int unsigned QUO_W    = 48,
    parameter int unsigned DIV_STEP = 16,
    parameter int unsigned MUL_STEP = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [FREQ_W-1:0]                xin_hz,
    input  logic [FREQ_W-1:0]                target_hz,
    input  logic [FREQ_W-1:0]                tol_hz,
    output logic                             done,
    output logic                             found,
    output logic [pllsrch_pkg::MODE_W-1:0]   mode_word,
    output logic [FREQ_W-1:0]                achieved_hz
);
    import pllsrch_pkg::*;

    localparam int unsigned PW = FREQ_W + MULB_W;

    st_e                  st;
    logic [CODE_W-1:0]    code;
    logic [DIVD_W-1:0]    divd;
    logic [FREQ_W-1:0]    xin_q, tgt_q, tol_q, best_err, best_freq;
    logic [QUO_W-1:0]     fpfd_r, mult_r, fvco_r, fout_r;
    logic [MODE_W-1:0]    best_mode;
    logic                 best_found;

    logic [POST_W-1:0]    post;
    logic [MULB_W-1:0]    pd;
    logic                 div_start, div_busy, div_done;
    logic [QUO_W-1:0]     div_num, div_quo, div_rnd;
    logic [FREQ_W-1:0]    div_den;
    logic                 mul_start, mul_busy, mul_done;
    logic [FREQ_W-1:0]    mul_a;
    logic [MULB_W-1:0]    mul_b;
    logic [PW-1:0]        mul_prod;
    logic                 pfd_ok, mult_ok, accept;
    logic [QUO_W-1:0]     cand_err;

    // Post value from the code, and the combined post*divd scale factor.
    always_comb begin
        post = (code == '0) ? POST_W'(1) : {code, 1'b0};
        pd   = MULB_W'(post) * MULB_W'(divd);
    end

    // Round-to-nearest from the doubled-dividend floor quotient.
    assign div_rnd = QUO_W'(({1'b0, div_quo} + (QUO_W+1)'(1)) >> 1);

    // Operand routing for the shared divider and multiplier.
    always_comb begin
        div_num = '0;
        div_den = '0;
        mul_a   = '0;
        mul_b   = '0;
        unique case (st)
            ST_PFD:  begin div_num = QUO_W'({xin_q, 1'b0});     div_den = FREQ_W'(divd); end
            ST_MDIV: begin div_num = QUO_W'({mul_prod, 1'b0});  div_den = xin_q;         end
            ST_VDIV: begin div_num = QUO_W'({mul_prod, 1'b0});  div_den = FREQ_W'(divd); end
            ST_ODIV: begin div_num = {fvco_r[QUO_W-2:0], 1'b0}; div_den = FREQ_W'(post); end
            ST_MULN: begin mul_a = tgt_q; mul_b = pd;                  end
            ST_MULV: begin mul_a = xin_q; mul_b = mult_r[MULB_W-1:0];  end
            default: ;
        endcase
        div_start = (st == ST_PFD || st == ST_MDIV || st == ST_VDIV || st == ST_ODIV)
                    && !div_busy && !div_done;
        mul_start = ((st == ST_MULN && pfd_ok) || (st == ST_MULV && mult_ok))
                    && !mul_busy && !mul_done;
    end

    pllsrch_div #(.NW(QUO_W), .DW(FREQ_W), .STEP(DIV_STEP)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(div_quo)
    );

    pllsrch_mul #(.AW(FREQ_W), .BW(MULB_W), .STEP(MUL_STEP)) u_mul (
        .clk(clk), .rst_n(rst_n), .start(mul_start), .a(mul_a), .b(mul_b),
        .busy(mul_busy), .done(mul_done), .prod(mul_prod)
    );

    pllsrch_judge #(.FW(FREQ_W), .QW(QUO_W)) u_judge (
        .xin(xin_q), .tgt(tgt_q), .tol(tol_q), .best_err(best_err),
        .fpfd(fpfd_r), .mult(mult_r), .fvco(fvco_r), .fout(fout_r),
        .pfd_ok(pfd_ok), .mult_ok(mult_ok), .accept(accept), .err(cand_err)
    );

    // Search sequencer: candidate stepping, best tracking, result publishing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            code        <= '0;
            divd        <= DIVD_W'(DIVD_TOP);
            xin_q       <= '0;
            tgt_q       <= '0;
            tol_q       <= '0;
            fpfd_r      <= '0;
            mult_r      <= '0;
            fvco_r      <= '0;
            fout_r      <= '0;
            best_err    <= '0;
            best_freq   <= '0;
            best_mode   <= '0;
            best_found  <= 1'b0;
            done        <= 1'b0;
            found       <= 1'b0;
            mode_word   <= '0;
            achieved_hz <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    xin_q      <= xin_hz;
                    tgt_q      <= target_hz;
                    tol_q      <= tol_hz;
                    best_err   <= tol_hz;
                    best_freq  <= '0;
                    best_mode  <= '0;
                    best_found <= 1'b0;
                    code       <= '0;
                    divd       <= DIVD_W'(DIVD_TOP);
                    st         <= ST_PFD;
                end
                ST_PFD:  if (div_done) begin fpfd_r <= div_rnd; st <= ST_MULN; end
                ST_MULN: if (!pfd_ok) st <= ST_ADV;
                         else if (mul_done) st <= ST_MDIV;
                ST_MDIV: if (div_done) begin mult_r <= div_rnd; st <= ST_MULV; end
                ST_MULV: if (!mult_ok) st <= ST_ADV;
                         else if (mul_done) st <= ST_VDIV;
                ST_VDIV: if (div_done) begin fvco_r <= div_rnd; st <= ST_ODIV; end
                ST_ODIV: if (div_done) begin fout_r <= div_rnd; st <= ST_JUDGE; end
                ST_JUDGE: begin
                    if (accept) begin
                        best_err   <= FREQ_W'(cand_err);
                        best_freq  <= FREQ_W'(fout_r);
                        best_mode  <= pack_mode(code, divd, mult_r[MULB_W-1:0]);
                        best_found <= 1'b1;
                    end
                    st <= ST_ADV;
                end
                ST_ADV: begin
                    if (divd == DIVD_W'(1)) begin
                        divd <= DIVD_W'(DIVD_TOP);
                        if (code == '1) st <= ST_FIN;
                        else begin code <= code + CODE_W'(1); st <= ST_PFD; end
                    end else begin
                        divd <= divd - DIVD_W'(1);
                        st   <= ST_PFD;
                    end
                end
                ST_FIN: begin
                    done        <= 1'b1;
                    found       <= best_found;
                    mode_word   <= best_mode;
                    achieved_hz <= best_freq;
                    st          <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

    AST_DIVD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (divd >= DIVD_W'(1)) && (divd <= DIVD_W'(DIVD_TOP))); // R2

    AST_DIVD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADV && divd != DIVD_W'(1)) |=>
        (divd == $past(divd) - DIVD_W'(1) && code == $past(code))); // R2

    AST_ACCEPT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_JUDGE && accept) |->
        (fpfd_r >= QUO_W'(PFD_MIN) && mult_r <= QUO_W'(MULT_MAX) && mult_r != '0
         && fvco_r >= QUO_W'(VCO_MIN))); // R4

    AST_ERR_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> (best_err <= $past(best_err))); // R5

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (mode_word == '0 && achieved_hz == '0)); // R6

    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (mode_word[24] && mode_word[3:0] == 4'b0011)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mode_word) && $stable(achieved_hz) && $stable(found))); // R9

endmodule

// File: tb/sim_pll_cfg_search.sv
`timescale 1ns/1ps
module sim_pll_cfg_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] xin_hz = '0, target_hz = '0, tol_hz = '0;
    logic        done, found;
    logic [24:0] mode_word;
    logic [31:0] achieved_hz;

    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned cyc = 0;

    pll_cfg_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .xin_hz(xin_hz),
        .target_hz(target_hz), .tol_hz(tol_hz), .done(done), .found(found),
        .mode_word(mode_word), .achieved_hz(achieved_hz)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 195000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog R1: actual=no done expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] rdiv(input logic [63:0] n, input logic [63:0] d);
        return (((n * 64'd2) / d) + 64'd1) >> 1;
    endfunction

    // Reference sweep built from the requirements.
    task automatic model(input logic [31:0] x, c, t,
                         output bit f, output logic [24:0] m, output logic [31:0] q);
        logic [63:0] best, p, mu, v, o, e, post;
        best = {32'd0, t};
        f = 1'b0; m = '0; q = '0;
        for (int code = 0; code < 16; code++) begin
            post = (code == 0) ? 64'd1 : 64'(2 * code);
            for (int d = 64; d >= 1; d--) begin
                p = rdiv({32'd0, x}, 64'(d));
                if (x == 0 || p < 64'd250000) continue;
                mu = rdiv({32'd0, c} * post * 64'(d), {32'd0, x});
                if (mu == 0 || mu > 64'd1024) continue;
                v = rdiv({32'd0, x} * mu, 64'(d));
                o = rdiv(v, post);
                e = (o >= {32'd0, c}) ? o - {32'd0, c} : {32'd0, c} - o;
                if (e <= best && v >= 64'd99000000 &&
                    (v <= 64'd201000000 || v <= {32'd0, c} + {32'd0, t})) begin
                    best = e;
                    f = 1'b1;
                    q = o[31:0];
                    m = {1'b1, 6'(d - 1), 10'(mu - 64'd1), 4'(code - 1), 4'b0011};
                end
            end
        end
    endtask

    task automatic run(input logic [31:0] x, c, t, input bit poke, input string tag);
        bit ef; logic [24:0] em; logic [31:0] eq;
        model(x, c, t, ef, em, eq);
        @(negedge clk);
        xin_hz = x; target_hz = c; tol_hz = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            xin_hz = x + 32'd1234567; target_hz = c >> 1; tol_hz = 32'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(found == ef, {tag, " R4 R6 R10 found"}, 64'(found), 64'(ef));
        check(mode_word == em, {tag, " R2 R5 R7 mode"}, 64'(mode_word), 64'(em));
        check(achieved_hz == eq, {tag, " R3 R8 freq"}, 64'(achieved_hz), 64'(eq));
        if (found)
            check(mode_word[24] == 1'b1 && mode_word[3:0] == 4'b0011,
                  {tag, " R7 fixed bits"}, 64'(mode_word), 64'(em));
        @(negedge clk);
        check(done == 1'b0, {tag, " R1 done width"}, 64'(done), 64'd0);
    endtask

    initial begin
        logic [24:0] hm; logic [31:0] hf; bit hfd;
        logic [31:0] rx, rc, rt;
        rx = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "reset R1 done", 64'(done), 64'd0);
        check(found == 1'b0, "reset R6 found", 64'(found), 64'd0);
        check(mode_word == '0, "reset R6 mode", 64'(mode_word), 64'd0);
        check(achieved_hz == '0, "reset R6 freq", 64'(achieved_hz), 64'd0);

        run(32'd20000000, 32'd250000000, 32'd0, 1'b1, "exact R1 ignored start");
        run(32'd12000000, 32'd148500000, 32'd1000, 1'b0, "fractional");

        hm = mode_word; hf = achieved_hz; hfd = found;
        @(negedge clk);
        xin_hz = 32'd7000000; target_hz = 32'd90000000; tol_hz = 32'd5;
        repeat (40) @(negedge clk);
        check(mode_word == hm, "R9 hold mode", 64'(mode_word), 64'(hm));
        check(achieved_hz == hf, "R9 hold freq", 64'(achieved_hz), 64'(hf));
        check(found == hfd, "R9 hold found", 64'(found), 64'(hfd));

        run(32'd20000000, 32'd333333333, 32'd100000, 1'b0, "vco ceiling R4");
        run(32'd4000000, 32'd1000000, 32'd0, 1'b0, "unreachable R6");
        run(32'd0, 32'd100000000, 32'd1000, 1'b0, "zero ref R10");

        for (int k = 0; k < 2; k++) begin
            rx = 32'd4000000 + ($urandom % 32'd4000000);
            rc = 32'd3300000 + ($urandom % 32'd300000000);
            rt = $urandom % 32'd200000;
            run(rx, rc, rt, 1'b0, "random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule